// File: doc/BRIEF.md
# PC-indexed reuse distance predictor

This block is a small set-associative table that links the address of a load or store instruction (its PC) to a predicted reuse distance. That distance belongs to the cache lines the instruction touches. Each distance is a 4-bit quantized value, and one unit stands for 8K last-level cache accesses. On every last-level access the cache presents the PC of the instruction on the lookup port. One cycle later the table returns a hit flag and the stored prediction. When the PC is not held, it returns a hit flag of 0 and a prediction of zero.

A separate update port carries the PC and the quantized distance that a sampling unit has just measured for it. If the PC is absent, the table allocates an entry for it. If the PC is present, the table either strengthens or weakens the stored prediction. Each entry has a 2-bit confidence counter that guards its prediction. The prediction can only be overwritten once that counter has dropped to zero, so a single noisy sample cannot replace a prediction that has held for a while.

The default table has 16 sets of 16 ways. Each set keeps a recency rank for every way, with rank 0 the most recently used and rank 15 the least recently used.

Top module: `rd_predictor`

## Requirements
- R1: After reset no PC is held, so every lookup returns hit 0 and prediction 0.
- R2: A lookup presented with lk_en high gives its result on pr_hit/pr_dist after the next rising clock edge. A miss gives pr_hit=0 and pr_dist=0. In a cycle with lk_en low, the following cycle shows pr_hit=0 and pr_dist=0.
- R3: An update for a PC that is not held allocates an entry with the sampled distance, and a later lookup of that PC returns hit 1 with that distance.
- R4: PC bits [3:0] select the set and bits [19:4] form the tag. A PC that shares the set but not the tag, or the tag but not the set, of a held PC misses.
- R5: An update hit whose distance equals the stored prediction raises the confidence counter by one, saturating at 3.
- R6: An update hit whose distance differs from the stored prediction, while confidence is above 0, lowers confidence by one and keeps the stored prediction.
- R7: An update hit whose distance differs from the stored prediction, while confidence is 0, replaces the prediction with the sampled distance.
- R8: A newly allocated entry starts with confidence 0, so the first differing sample replaces its prediction.
- R9: An update miss fills the least recently used way of the indexed set. A set that holds 16 PCs evicts the PC used longest ago when a 17th arrives.
- R10: A lookup hit and an update both make the touched way the most recently used of its set.
- R11: When a lookup and an update arrive in the same cycle, the update is applied first, and the lookup result reflects the updated table.
- R12: Within every set, the recency ranks of the 16 ways always form a permutation of 0..15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request |
| lk_pc | input | 20 | PC of the accessing instruction |
| up_en | input | 1 | Update request from the sampling unit |
| up_pc | input | 20 | PC whose reuse distance was sampled |
| up_dist | input | 4 | Sampled quantized reuse distance |
| pr_hit | output | 1 | Lookup found the PC (registered) |
| pr_dist | output | 4 | Predicted distance, zero on a miss (registered) |

## Verification
The hardest state to reach from the ports is a full set. In that state eviction depends on the exact order of past lookups and updates, and it matters most when a lookup in the same cycle as an update reorders recency. Directed runs fill one set with 16 tags, touch the oldest, and then push a 17th tag. A seeded random phase uses about 20 tags over 4 sets, so sets overflow constantly while lookups and updates overlap. The confidence rules are driven in fixed sequences: four matching samples followed by four differing ones. These show both the saturation at 3 and the point at which the prediction finally changes.

// File: rtl/rd_predictor.sv
module rd_predictor #(
  parameter int SETS    = 16,
  parameter int WAYS    = 16,
  parameter int PC_BITS = 20,
  parameter int DIST_W  = 4,
  parameter int CONF_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_en,
  input  logic [PC_BITS-1:0] lk_pc,
  input  logic               up_en,
  input  logic [PC_BITS-1:0] up_pc,
  input  logic [DIST_W-1:0]  up_dist,
  output logic               pr_hit,
  output logic [DIST_W-1:0]  pr_dist
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_BITS - IDX_W;
  localparam int AGE_W = $clog2(WAYS);
  localparam logic [AGE_W-1:0]  OLDEST   = AGE_W'(WAYS - 1);
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  logic              vld  [SETS][WAYS];
  logic [TAG_W-1:0]  tag  [SETS][WAYS];
  logic [DIST_W-1:0] pred [SETS][WAYS];
  logic [CONF_W-1:0] conf [SETS][WAYS];
  logic [AGE_W-1:0]  age  [SETS][WAYS];

  logic              n_vld  [SETS][WAYS];
  logic [TAG_W-1:0]  n_tag  [SETS][WAYS];
  logic [DIST_W-1:0] n_pred [SETS][WAYS];
  logic [CONF_W-1:0] n_conf [SETS][WAYS];
  logic [AGE_W-1:0]  n_age  [SETS][WAYS];

  wire [IDX_W-1:0] ui = up_pc[IDX_W-1:0];
  wire [TAG_W-1:0] ut = up_pc[PC_BITS-1:IDX_W];
  wire [IDX_W-1:0] li = lk_pc[IDX_W-1:0];
  wire [TAG_W-1:0] lt = lk_pc[PC_BITS-1:IDX_W];

  logic              u_hit, l_hit;
  logic [AGE_W-1:0]  u_way, l_way, u_rank, l_rank;
  logic [DIST_W-1:0] l_pred;

  always_comb begin
    n_vld = vld; n_tag = tag; n_pred = pred; n_conf = conf; n_age = age;
    u_hit = 1'b0; u_way = '0; u_rank = '0;
    l_hit = 1'b0; l_way = '0; l_rank = '0; l_pred = '0;

    if (up_en) begin
      for (int w = 0; w < WAYS; w++)
        if (vld[ui][w] && tag[ui][w] == ut) begin
          u_hit = 1'b1;
          u_way = AGE_W'(w);
        end
      if (!u_hit)
        for (int w = 0; w < WAYS; w++)
          if (age[ui][w] == OLDEST) u_way = AGE_W'(w);
      if (!u_hit) begin
        n_vld[ui][u_way]  = 1'b1;
        n_tag[ui][u_way]  = ut;
        n_pred[ui][u_way] = up_dist;
        n_conf[ui][u_way] = '0;
      end else if (pred[ui][u_way] == up_dist) begin
        if (conf[ui][u_way] != CONF_MAX) n_conf[ui][u_way] = conf[ui][u_way] + 1'b1;
      end else if (conf[ui][u_way] == '0) begin
        n_pred[ui][u_way] = up_dist;
      end else begin
        n_conf[ui][u_way] = conf[ui][u_way] - 1'b1;
      end
      u_rank = age[ui][u_way];
      for (int w = 0; w < WAYS; w++)
        if (age[ui][w] < u_rank) n_age[ui][w] = age[ui][w] + 1'b1;
      n_age[ui][u_way] = '0;
    end

    if (lk_en) begin
      for (int w = 0; w < WAYS; w++)
        if (n_vld[li][w] && n_tag[li][w] == lt) begin
          l_hit = 1'b1;
          l_way = AGE_W'(w);
        end
      if (l_hit) begin
        l_pred = n_pred[li][l_way];
        l_rank = n_age[li][l_way];
        for (int w = 0; w < WAYS; w++)
          if (n_age[li][w] < l_rank) n_age[li][w] = n_age[li][w] + 1'b1;
        n_age[li][l_way] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w]  <= 1'b0;
          tag[s][w]  <= '0;
          pred[s][w] <= '0;
          conf[s][w] <= '0;
          age[s][w]  <= AGE_W'(w);
        end
      pr_hit  <= 1'b0;
      pr_dist <= '0;
    end else begin
      vld  <= n_vld;
      tag  <= n_tag;
      pred <= n_pred;
      conf <= n_conf;
      age  <= n_age;
      pr_hit  <= lk_en && l_hit;
      pr_dist <= (lk_en && l_hit) ? l_pred : '0;
    end
  end
endmodule

module rd_predictor_chk #(
  parameter int SETS    = 16,
  parameter int WAYS    = 16,
  parameter int PC_BITS = 20,
  parameter int DIST_W  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       lk_en,
  input logic [PC_BITS-1:0]         lk_pc,
  input logic                       up_en,
  input logic [PC_BITS-1:0]         up_pc,
  input logic                       pr_hit,
  input logic [DIST_W-1:0]          pr_dist,
  input logic [$clog2(WAYS)-1:0]    age [SETS][WAYS]
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> (!pr_hit && pr_dist == '0));

  // R2
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_hit |-> pr_dist == '0);

  // R11
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && lk_en && up_pc == lk_pc) |=> pr_hit);

  // R3
  alloc_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up_en) && lk_en && lk_pc == $past(up_pc)) |=> pr_hit);

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0] seen;
    always_comb begin
      seen = '0;
      for (int w = 0; w < WAYS; w++) seen[age[s][w]] = 1'b1;
    end
    // R12
    rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) &seen);
  end
endmodule

bind rd_predictor rd_predictor_chk #(
  .SETS(SETS), .WAYS(WAYS), .PC_BITS(PC_BITS), .DIST_W(DIST_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_pc(lk_pc), .up_en(up_en),
  .up_pc(up_pc), .pr_hit(pr_hit), .pr_dist(pr_dist), .age(age)
);

// File: tb/test_rd_predictor.sv
`timescale 1ns/1ps
module test_rd_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_en = 1'b0, up_en = 1'b0;
  logic [19:0] lk_pc = '0, up_pc = '0;
  logic [3:0]  up_dist = '0;
  logic        pr_hit;
  logic [3:0]  pr_dist;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rd_predictor i_rd_predictor (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_pc(lk_pc), .up_en(up_en),
    .up_pc(up_pc), .up_dist(up_dist), .pr_hit(pr_hit), .pr_dist(pr_dist)
  );

  bit          mv [16][16];
  logic [15:0] mt [16][16];
  logic [3:0]  mp [16][16];
  int          mc [16][16];
  int          ms [16][16];
  int          now = 1;

  function automatic int mfind(logic [19:0] pc);
    for (int w = 0; w < 16; w++)
      if (mv[pc[3:0]][w] && mt[pc[3:0]][w] == pc[19:4]) return w;
    return -1;
  endfunction

  task automatic m_update(logic [19:0] pc, logic [3:0] d);
    int s, w;
    s = pc[3:0];
    w = mfind(pc);
    if (w < 0) begin
      w = 0;
      for (int k = 0; k < 16; k++)
        if (!mv[s][k]) begin w = k; break; end
        else if (ms[s][k] < ms[s][w]) w = k;
      mv[s][w] = 1; mt[s][w] = pc[19:4]; mp[s][w] = d; mc[s][w] = 0;
    end else if (mp[s][w] == d) begin
      if (mc[s][w] < 3) mc[s][w]++;
    end else if (mc[s][w] == 0) mp[s][w] = d;
    else mc[s][w]--;
    ms[s][w] = now++;
  endtask

  task automatic m_lookup(logic [19:0] pc, output bit h, output logic [3:0] d);
    int w;
    w = mfind(pc);
    h = (w >= 0);
    d = h ? mp[pc[3:0]][w] : 4'd0;
    if (h) ms[pc[3:0]][w] = now++;
  endtask

  task automatic step(bit le, logic [19:0] lp, bit ue, logic [19:0] upc,
                      logic [3:0] ud, string req);
    bit eh;
    logic [3:0] ed;
    lk_en = le; lk_pc = lp; up_en = ue; up_pc = upc; up_dist = ud;
    if (ue) m_update(upc, ud);
    eh = 0; ed = 0;
    if (le) m_lookup(lp, eh, ed);
    @(negedge clk);
    checks++;
    if (pr_hit !== eh || pr_dist !== ed) begin
      errors++;
      $display("FAIL %s: hit/dist actual %0b/%0d expected %0b/%0d", req, pr_hit, pr_dist, eh, ed);
    end
    lk_en = 0; up_en = 0;
  endtask

  task automatic look(logic [19:0] pc, string req);
    step(1, pc, 0, 20'h0, 4'd0, req);
  endtask

  task automatic upd(logic [19:0] pc, logic [3:0] d, string req);
    step(0, 20'h0, 1, pc, d, req);
  endtask

  initial begin
    #(4 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [19:0] a_pc, b_pc;
    int seed;
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 16; w++) begin mv[s][w] = 0; ms[s][w] = 0; end
    seed = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    checks++;
    if (pr_hit !== 1'b0 || pr_dist !== 4'd0) begin
      errors++;
      $display("FAIL R1: hit/dist actual %0b/%0d expected 0/0", pr_hit, pr_dist);
    end
    look(20'h00000, "R1");
    look(20'h00005, "R1");
    look(20'hFFFFF, "R1");
    // R2 idle cycle
    step(0, 20'h12345, 0, 20'h0, 4'd0, "R2");
    // R3 allocate then read
    upd(20'h12345, 4'd7, "R3");
    look(20'h12345, "R3");
    step(0, 20'h12345, 0, 20'h0, 4'd0, "R2");
    // R4 set / tag separation
    look(20'h12355, "R4");
    look(20'h12344, "R4");
    // R5 saturation then R6 decrements then R7 replacement
    a_pc = 20'h00A21;
    upd(a_pc, 4'd5, "R3");
    repeat (4) upd(a_pc, 4'd5, "R5");
    repeat (3) upd(a_pc, 4'd9, "R6");
    look(a_pc, "R6");
    upd(a_pc, 4'd9, "R7");
    look(a_pc, "R7");
    // R8 fresh entry has zero confidence
    b_pc = 20'h00B23;
    upd(b_pc, 4'd3, "R8");
    upd(b_pc, 4'd6, "R8");
    look(b_pc, "R8");
    // R9 / R10 full set eviction order
    for (int t = 0; t < 16; t++) upd({16'h0100 + 16'(t), 4'h2}, 4'(t), "R9");
    look({16'h0100, 4'h2}, "R10");
    upd({16'h0110, 4'h2}, 4'd1, "R9");
    look({16'h0101, 4'h2}, "R9");
    look({16'h0100, 4'h2}, "R10");
    look({16'h0110, 4'h2}, "R9");
    // R11 same-cycle update and lookup
    step(1, 20'h7777E, 1, 20'h7777E, 4'd11, "R11");
    step(1, a_pc, 1, a_pc, 4'd4, "R11");
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [19:0] p1, p2;
      p1 = {16'($urandom_range(0, 19)), 4'($urandom_range(0, 3))};
      p2 = ($urandom_range(0, 3) == 0) ? p1 :
           {16'($urandom_range(0, 19)), 4'($urandom_range(0, 3))};
      step(1'($urandom_range(0, 1)), p2, 1'($urandom_range(0, 1)), p1,
           4'($urandom_range(0, 3)), "R9/R10 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule